// File: doc/BRIEF.md
# Unified almost Montgomery inverse engine

This block computes the first half of a Montgomery-domain modular inversion. It is given an operand `a` and a modulus `p` and returns an almost inverse `x` with an iteration count `k` such that `x·a ≡ 2^k (mod p)`. In binary-polynomial mode the same holds with `x^k` in place of `2^k` and carry-free polynomial multiplication. A separate stage that turns `2^k` into the final Montgomery factor is expected to follow it.

One bit-serial datapath serves both field types. Each clock cycle it performs one shift or shift-after-subtract step on the four working registers. In binary mode every add and subtract becomes an XOR. The magnitude comparison that picks between the two subtract branches stays an ordinary carry-propagate compare in both modes. After the loop, a short correction stage brings the residue below the modulus.

A caller drives operands together with a one-cycle `start` in idle. It then waits for the one-cycle `done` pulse and reads the held results.

Top module: `mont_almost_inv`

## Requirements
- R1: After a synchronous active-high reset, and after a reset applied in the middle of a computation, `done` is 0, `r_out` is 0 and `k_out` is 0.
- R2: A `start` seen while idle captures `mode`, `a` and `p` and clears the count. While a computation is running, `start`, `mode`, `a` and `p` are ignored, and the result and its latency are those of the captured operands.
- R3: While the working value v is nonzero, exactly one step runs per clock and the count rises by one per step. If u is even, u is halved and s doubled. Else, if v is even, v is halved and r doubled.
- R4: When u and v are both odd and u>v, u becomes (u−v)/2, r becomes r+s and s is doubled. Otherwise v becomes (v−u)/2, s becomes s+r and r is doubled.
- R5: `mode`=0 selects prime-field arithmetic and `mode`=1 selects binary-polynomial arithmetic. In mode 1, every add or subtract of u, v, r and s is a bitwise XOR, while the u>v test remains an unsigned integer compare.
- R6: In mode 0, once the loop ends, p is subtracted from r while r ≥ p, and `r_out` = p−r. For odd p < 2^N and 1 ≤ a < p, this gives 1 ≤ `r_out` < p and `r_out`·a ≡ 2^`k_out` (mod p).
- R7: In mode 1 (p has bit N set), r is reduced by XOR with p, or with p shifted left once, until bits above N−1 are clear, and `r_out` = r. For a nonzero a this gives `r_out`[N] = 0 and `r_out`·a ≡ x^`k_out` (mod p) under carry-free multiplication.
- R8: `k_out` never exceeds 2N. In mode 0, it is at least the bit length of p.
- R9: `done` is high for exactly one cycle, k+2+f clock edges after the edge that sampled `start`, where f is the number of correction subtractions. `r_out` and `k_out` change only together with that pulse and hold until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation when idle |
| mode | input | 1 | 0 = prime field, 1 = binary polynomial field |
| a | input | N | Operand to invert |
| p | input | N+1 | Modulus; in mode 1 bit N is the leading term |
| done | output | 1 | One-cycle result-valid pulse |
| r_out | output | N+1 | Almost inverse |
| k_out | output | $clog2(2N+1)+1 | Iteration count k |

## Verification
The range assertions on the result assume that the caller provides an invertible operand. In mode 0 that means an odd p with bit N clear and a in 1..p−1. In mode 1 it means a p with bit N set and no common factor with a nonzero a. The stimulus keeps to these conditions. It uses only prime moduli in mode 0 and one fixed irreducible degree-N polynomial in mode 1, and it never starts a run with a zero operand. The busy-start and mid-run reset cases use the same valid operand sets, so the assertions stay armed throughout.

// File: rtl/mai_pkg.sv
package mai_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_FIX  = 2'd2
    } mai_state_e;

    typedef enum logic {
        FIELD_PRIME = 1'b0,
        FIELD_BIN   = 1'b1
    } mai_field_e;

    typedef enum logic [1:0] {
        BR_HALVE_U = 2'd0,
        BR_HALVE_V = 2'd1,
        BR_SUB_U   = 2'd2,
        BR_SUB_V   = 2'd3
    } mai_branch_e;

    // Branch selection: evenness of u first, then of v, then magnitude.
    function automatic mai_branch_e pick_branch(input logic u_lsb,
                                                input logic v_lsb,
                                                input logic u_gt_v);
        if (!u_lsb)      return BR_HALVE_U;
        else if (!v_lsb) return BR_HALVE_V;
        else if (u_gt_v) return BR_SUB_U;
        else             return BR_SUB_V;
    endfunction

endpackage

// File: rtl/mai_addsub.sv
module mai_addsub
    import mai_pkg::*;
#(
    parameter int W = 18
) (
    input  mai_field_e     field,
    input  logic           sub,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [W-1:0]   z
);
    // Carry-free in binary mode; two's complement add/sub otherwise.
    always_comb begin
        if (field == FIELD_BIN) z = x ^ y;
        else if (sub)           z = x - y;
        else                    z = x + y;
    end
endmodule

// File: rtl/mai_step.sv
module mai_step
    import mai_pkg::*;
#(
    parameter int N = 16,
    parameter int W = N + 2
) (
    input  mai_field_e   field,
    input  logic [N:0]   u,
    input  logic [N:0]   v,
    input  logic [W-1:0] r,
    input  logic [W-1:0] s,
    output logic [N:0]   u_nx,
    output logic [N:0]   v_nx,
    output logic [W-1:0] r_nx,
    output logic [W-1:0] s_nx
);
    logic [N:0]   d_uv;
    logic [N:0]   d_vu;
    logic [W-1:0] sum_rs;
    logic         u_gt_v;
    mai_branch_e  br;

    mai_addsub #(.W(N+1)) i_sub_uv (.field(field), .sub(1'b1), .x(u), .y(v), .z(d_uv));
    mai_addsub #(.W(N+1)) i_sub_vu (.field(field), .sub(1'b1), .x(v), .y(u), .z(d_vu));
    mai_addsub #(.W(W))   i_add_rs (.field(field), .sub(1'b0), .x(r), .y(s), .z(sum_rs));

    // Degree/magnitude test is a carry compare in both fields.
    assign u_gt_v = (u > v);
    assign br     = pick_branch(u[0], v[0], u_gt_v);

    always_comb begin
        u_nx = u;
        v_nx = v;
        r_nx = r;
        s_nx = s;
        unique case (br)
            BR_HALVE_U: begin
                u_nx = u >> 1;
                s_nx = s << 1;
            end
            BR_HALVE_V: begin
                v_nx = v >> 1;
                r_nx = r << 1;
            end
            BR_SUB_U: begin
                u_nx = d_uv >> 1;
                r_nx = sum_rs;
                s_nx = s << 1;
            end
            default: begin
                v_nx = d_vu >> 1;
                s_nx = sum_rs;
                r_nx = r << 1;
            end
        endcase
    end
endmodule

// File: rtl/mai_fix.sv
module mai_fix
    import mai_pkg::*;
#(
    parameter int N = 16,
    parameter int W = N + 2
) (
    input  mai_field_e   field,
    input  logic [W-1:0] r,
    input  logic [N:0]   p,
    output logic         need,
    output logic [W-1:0] r_red,
    output logic [N:0]   result
);
    localparam int PAD = W - (N + 1);

    logic [W-1:0] p_w;
    assign p_w = {{PAD{1'b0}}, p};

    always_comb begin
        if (field == FIELD_BIN) begin
            // Degree must fall below N; top bit first, one term per cycle.
            need   = |r[W-1:N];
            r_red  = r[W-1] ? (r ^ (p_w << 1)) : (r ^ p_w);
            result = r[N:0];
        end else begin
            need   = (r >= p_w);
            r_red  = r - p_w;
            result = p - r[N:0];
        end
    end
endmodule

// File: rtl/mont_almost_inv.sv
module mont_almost_inv
    import mai_pkg::*;
#(
    parameter int N = 16,
    localparam int W  = N + 2,
    localparam int KW = $clog2(2 * N + 1) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode,
    input  logic [N-1:0]  a,
    input  logic [N:0]    p,
    output logic          done,
    output logic [N:0]    r_out,
    output logic [KW-1:0] k_out
);
    typedef struct packed {
        logic [N:0]   u;
        logic [N:0]   v;
        logic [W-1:0] r;
        logic [W-1:0] s;
    } work_t;

    mai_state_e    state_q;
    mai_field_e    field_q;
    logic [N:0]    p_q;
    work_t         wk_q;
    work_t         wk_nx;
    logic [KW-1:0] k_q;
    logic          done_q;
    logic [N:0]    r_out_q;
    logic [KW-1:0] k_out_q;
    logic          v_zero;
    logic          fix_need;
    logic [W-1:0]  fix_r;
    logic [N:0]    fix_res;

    assign v_zero = (wk_q.v == '0);

    mai_step #(.N(N), .W(W)) i_step (
        .field (field_q),
        .u     (wk_q.u),
        .v     (wk_q.v),
        .r     (wk_q.r),
        .s     (wk_q.s),
        .u_nx  (wk_nx.u),
        .v_nx  (wk_nx.v),
        .r_nx  (wk_nx.r),
        .s_nx  (wk_nx.s)
    );

    mai_fix #(.N(N), .W(W)) i_fix (
        .field  (field_q),
        .r      (wk_q.r),
        .p      (p_q),
        .need   (fix_need),
        .r_red  (fix_r),
        .result (fix_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            field_q <= FIELD_PRIME;
            p_q     <= '0;
            wk_q    <= '0;
            k_q     <= '0;
            done_q  <= 1'b0;
            r_out_q <= '0;
            k_out_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        field_q <= mai_field_e'(mode);
                        p_q     <= p;
                        wk_q.u  <= p;
                        wk_q.v  <= {1'b0, a};
                        wk_q.r  <= '0;
                        wk_q.s  <= W'(1);
                        k_q     <= '0;
                        state_q <= ST_LOOP;
                    end
                end
                ST_LOOP: begin
                    if (v_zero) begin
                        state_q <= ST_FIX;
                    end else begin
                        wk_q <= wk_nx;
                        k_q  <= k_q + KW'(1);
                    end
                end
                ST_FIX: begin
                    if (fix_need) begin
                        wk_q.r <= fix_r;
                    end else begin
                        r_out_q <= fix_res;
                        k_out_q <= k_q;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done  = done_q;
    assign r_out = r_out_q;
    assign k_out = k_out_q;

endmodule

// File: rtl/mai_checker.sv
module mai_checker
    import mai_pkg::*;
#(
    parameter int N  = 16,
    parameter int KW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input logic [N:0]    r_out,
    input logic [KW-1:0] k_out,
    input mai_state_e    state,
    input mai_field_e    field,
    input logic          v_zero,
    input logic [KW-1:0] k_cnt,
    input logic [N:0]    p_held
);
    AST_LOAD_ON_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (state == ST_LOOP && k_cnt == '0)); // R2

    AST_BUSY_HOLDS_OPERANDS: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ($stable(p_held) && $stable(field))); // R2

    AST_ONE_STEP_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOP && !v_zero) |=> (state == ST_LOOP && k_cnt == $past(k_cnt) + 1'b1)); // R3

    AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOP && v_zero) |=> (state == ST_FIX && k_cnt == $past(k_cnt))); // R3

    AST_PRIME_RANGE: assert property (@(posedge clk) disable iff (rst)
        (done && field == FIELD_PRIME) |-> (r_out < p_held && r_out != '0)); // R6

    AST_BIN_REDUCED: assert property (@(posedge clk) disable iff (rst)
        (done && field == FIELD_BIN) |-> !r_out[N]); // R7

    AST_K_CEILING: assert property (@(posedge clk) disable iff (rst)
        done |-> (k_out <= KW'(2 * N))); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FIX) |=> ($stable(r_out) && $stable(k_out))); // R9

endmodule

bind mont_almost_inv mai_checker #(.N(N), .KW(KW)) i_mai_checker (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .r_out  (r_out),
    .k_out  (k_out),
    .state  (state_q),
    .field  (field_q),
    .v_zero (v_zero),
    .k_cnt  (k_q),
    .p_held (p_q)
);

// File: tb/test_mont_almost_inv.sv
module test_mont_almost_inv;
    localparam int N  = 16;
    localparam int KW = $clog2(2 * N + 1) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [N-1:0]  a = '0;
    logic [N:0]    p = '0;
    logic          done;
    logic [N:0]    r_out;
    logic [KW-1:0] k_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    mont_almost_inv #(.N(N)) i_mont_almost_inv (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .a(a), .p(p), .done(done), .r_out(r_out), .k_out(k_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference of the whole algorithm on plain integers.
    task automatic model(input bit bin, input longint av, input longint pv,
                         output longint x, output int k, output int f);
        longint u = pv, v = av, r = 0, s = 1;
        k = 0;
        f = 0;
        while (v != 0) begin
            if (u % 2 == 0) begin
                u = u / 2; s = s * 2;
            end else if (v % 2 == 0) begin
                v = v / 2; r = r * 2;
            end else if (u > v) begin
                u = (bin ? (u ^ v) : (u - v)) / 2;
                r = bin ? (r ^ s) : (r + s);
                s = s * 2;
            end else begin
                v = (bin ? (v ^ u) : (v - u)) / 2;
                s = bin ? (s ^ r) : (s + r);
                r = r * 2;
            end
            k++;
        end
        if (bin) begin
            while ((r >> N) != 0) begin
                if ((r >> (N + 1)) != 0) r = r ^ (pv << 1);
                else                     r = r ^ pv;
                f++;
            end
            x = r;
        end else begin
            while (r >= pv) begin
                r = r - pv;
                f++;
            end
            x = pv - r;
        end
    endtask

    function automatic longint pow2_mod(input int k, input longint m);
        longint t = 1 % m;
        for (int i = 0; i < k; i++) t = (t * 2) % m;
        return t;
    endfunction

    function automatic longint gf_reduce(input longint x, input longint m);
        longint t = x;
        for (int b = 2 * N + 2; b >= N; b--)
            if (((t >> b) & 1) != 0) t = t ^ (m << (b - N));
        return t;
    endfunction

    function automatic longint gf_mulmod(input longint x, input longint y, input longint m);
        longint acc = 0;
        for (int i = 0; i <= N; i++)
            if (((y >> i) & 1) != 0) acc = acc ^ (x << i);
        return gf_reduce(acc, m);
    endfunction

    function automatic longint gf_xpow(input int k, input longint m);
        longint t = 1;
        for (int i = 0; i < k; i++) t = gf_reduce(t << 1, m);
        return t;
    endfunction

    function automatic int bitlen(input longint x);
        int b = 0;
        for (int i = 0; i < 40; i++) if (((x >> i) & 1) != 0) b = i + 1;
        return b;
    endfunction

    // One computation; poke drives a second start with other operands mid-run (R2).
    task automatic run(input bit bin, input longint av, input longint pv, input bit poke);
        longint ex;
        int ek, ef, lat;
        bit early;
        model(bin, av, pv, ex, ek, ef);
        lat = ek + 2 + ef;
        @(negedge clk);
        start = 1'b1; mode = bin; a = N'(av); p = (N+1)'(pv);
        early = 1'b0;
        for (int i = 1; i <= lat; i++) begin
            @(negedge clk);
            if (i == 1) start = 1'b0;
            if (poke && i == 3) begin
                start = 1'b1; mode = ~bin; a = N'(av ^ 16'h0005); p = (N+1)'(pv ^ 17'h2);
            end
            if (poke && i == 4) start = 1'b0;
            if (done) early = 1'b1;
        end
        check(!early, poke ? "R2" : "R9", "done before expected edge", early, 0);
        @(negedge clk);
        check(done == 1'b1, "R9", "done at k+2+f edges", done, 1);
        check(r_out == (N+1)'(ex), bin ? "R7" : "R6", "r_out vs reference", r_out, ex);
        check(k_out == KW'(ek), "R3", "k_out vs reference", k_out, ek);
        if (bin) begin
            check(gf_mulmod(r_out, av, pv) == gf_xpow(k_out, pv), "R7",
                  "r_out*a vs x^k mod p", gf_mulmod(r_out, av, pv), gf_xpow(k_out, pv));
            check(r_out[N] == 1'b0, "R7", "degree below N", r_out[N], 0);
        end else begin
            check(((r_out * av) % pv) == pow2_mod(k_out, pv), "R6",
                  "r_out*a vs 2^k mod p", (r_out * av) % pv, pow2_mod(k_out, pv));
            check(k_out >= bitlen(pv), "R8", "k lower bound", k_out, bitlen(pv));
        end
        check(k_out <= 2 * N, "R8", "k upper bound", k_out, 2 * N);
        @(negedge clk);
        check(done == 1'b0, "R9", "done single cycle", done, 0);
        check(r_out == (N+1)'(ex) && k_out == KW'(ek), "R9", "result held after pulse", r_out, ex);
    endtask

    initial begin
        longint lf;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0 && r_out == '0 && k_out == '0, "R1", "reset outputs", r_out, 0);
        rst = 1'b0;

        // R4 R5 prime field, including small exhaustive modulus
        run(1'b0, 2, 3, 1'b0);
        run(1'b0, 1, 3, 1'b0);
        for (int i = 1; i < 13; i++) run(1'b0, i, 13, 1'b0);
        run(1'b0, 1, 65521, 1'b0);
        run(1'b0, 2, 65521, 1'b0);
        run(1'b0, 65520, 65521, 1'b0);
        run(1'b0, 12345, 65521, 1'b0);
        lf = 16'hACE1;
        for (int i = 0; i < 8; i++) begin
            lf = ((lf >> 1) | ((((lf >> 0) ^ (lf >> 2) ^ (lf >> 3) ^ (lf >> 5)) & 1) << 15)) & 16'hFFFF;
            run(1'b0, (lf % 65520) + 1, 65521, 1'b0);
            run(1'b0, (lf % 250) + 1, 251, 1'b0);
        end

        // R5 R7 binary field, irreducible x^16+x^5+x^3+x^2+1
        run(1'b1, 1, 17'h1002D, 1'b0);
        run(1'b1, 2, 17'h1002D, 1'b0);
        run(1'b1, 16'h8000, 17'h1002D, 1'b0);
        run(1'b1, 16'hFFFF, 17'h1002D, 1'b0);
        run(1'b1, 16'h1234, 17'h1002D, 1'b0);
        for (int i = 0; i < 8; i++) begin
            lf = ((lf >> 1) | ((((lf >> 0) ^ (lf >> 2) ^ (lf >> 3) ^ (lf >> 5)) & 1) << 15)) & 16'hFFFF;
            run(1'b1, (lf == 0) ? 1 : lf, 17'h1002D, 1'b0);
        end

        // R2: start, mode and operands ignored while busy
        run(1'b0, 12345, 65521, 1'b1);
        run(1'b1, 16'h1234, 17'h1002D, 1'b1);

        // R1: reset in the middle of a run
        @(negedge clk);
        start = 1'b1; mode = 1'b0; a = 16'd777; p = 17'd65521;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && r_out == '0 && k_out == '0, "R1", "mid-run reset clears", r_out, 0);
        repeat (40) @(negedge clk);
        check(done == 1'b0 && r_out == '0, "R1", "no result after mid-run reset", done, 0);
        run(1'b0, 777, 65521, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule